// File: doc/BRIEF.md
# Image Sensor Readout Sequencer

This block produces the timing strobes that step an image sensor's row and column shift registers through a rectangular window of the pixel array. A frame request made while the block is idle starts one frame. In rolling-shutter mode the frame is readout only. In global-shutter mode an exposure interval comes first. That interval is marked by a shutter-open pulse and a shutter-close pulse, and readout follows straight after the close pulse. Each line opens with a row-advance pulse and a programmable blanking interval. One pixel per clock then follows across the programmed width, and the block reports the current row and column addresses as it goes.

The window origin, size, blanking length, exposure length and frame mode are all sampled when a request is accepted, and they hold for the whole frame. The column origin is always aligned to an even address, because the column shift register moves in steps of two. The row origin may be any line. All outputs are decoded from registers clocked on the rising edge of the system clock.

Top module: `sensor_readout_seq`

## Requirements
- R1: While reset is held and while idle after reset, every strobe output (`frame_start_o`, `row_adv_o`, `col_load_o`, `shut_open_o`, `shut_close_o`, `pix_valid_o`, `frame_done_o`) is 0.
- R2: In rolling mode (`global_mode_i`=0), a request sampled at an idle edge gives `frame_start_o`=1 for the next cycle. The frame then takes H·(B+W) cycles, and `frame_done_o` is 1 for the single cycle after the last pixel.
- R3: Each line begins with one cycle of `row_adv_o`=1, which is the first of B blanking cycles. W consecutive cycles with `pix_valid_o`=1 follow. The first line begins the cycle after `frame_start_o`.
- R4: `col_load_o` is 1 in exactly the cycle before the first pixel of each line. When B=1 it coincides with `row_adv_o`.
- R5: `pixel_o` equals the column origin with bit 0 cleared, plus the pixel index within the line. `line_o` equals the row origin plus the line index. Both are valid while `pix_valid_o`=1.
- R6: In global mode (`global_mode_i`=1), `shut_open_o` is 1 in the cycle after acceptance and `shut_close_o` is 1 exactly I cycles later. `frame_start_o` follows in the next cycle, and readout then proceeds as in rolling mode.
- R7: A value of 0 for blanking B, integration I, width W or height H is treated as 1.
- R8: A request arriving while a frame is in progress is ignored. Changes to the mode or window inputs during a frame have no effect on that frame.
- R9: A request sampled in the `frame_done_o` cycle is accepted, and the next frame starts without an idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Frame request |
| global_mode_i | input | 1 | 1 selects global shutter, 0 selects rolling shutter |
| roi_x_i | input | X_W | Column origin of the window (bit 0 ignored) |
| roi_y_i | input | Y_W | Row origin of the window |
| width_i | input | X_W | Pixels per line W |
| height_i | input | Y_W | Lines per frame H |
| blank_cyc_i | input | T_W | Row blanking length B in clock cycles |
| integ_cyc_i | input | T_W | Exposure length I in clock cycles |
| frame_start_o | output | 1 | Starts the row shift register for a frame |
| row_adv_o | output | 1 | Per-line row advance, starts the column shift register |
| col_load_o | output | 1 | Loads the column origin ahead of a line's pixels |
| shut_open_o | output | 1 | Exposure begins |
| shut_close_o | output | 1 | Exposure ends |
| pix_valid_o | output | 1 | A pixel is being read this cycle |
| line_o | output | Y_W | Current row address |
| pixel_o | output | X_W | Current column address |
| frame_done_o | output | 1 | One cycle after the last pixel of the frame |

## Verification
Two pairs of events can land in the same cycle. The first pair is the row-advance pulse and the column-load pulse: with a one-cycle blanking setting (programmed directly or reached from a zero setting) both fall on the first cycle of every line. The bench checks every cycle of such frames against a cycle-indexed model. The second pair is frame completion and a new request: the bench raises the request exactly in the frame-done cycle and expects the next frame-start pulse in the following cycle, then confirms that the chained frame finishes on schedule. A request raised mid-frame, together with changed mode and window inputs, is shown to change nothing in the frame under way.

// File: rtl/readout_seq_pkg.sv
package readout_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_EXPOSE,
    ST_FSTART,
    ST_BLANK,
    ST_PIXEL,
    ST_DONE
  } seq_state_e;
endpackage

// File: rtl/readout_cfg.sv
module readout_cfg #(
  parameter int X_W = 11,
  parameter int Y_W = 10,
  parameter int T_W = 16,
  parameter int X_ALIGN_LOG2 = 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic [X_W-1:0] roi_x_i,
  input  logic [Y_W-1:0] roi_y_i,
  input  logic [X_W-1:0] width_i,
  input  logic [Y_W-1:0] height_i,
  input  logic [T_W-1:0] blank_i,
  input  logic [T_W-1:0] integ_i,
  output logic [X_W-1:0] x0_o,
  output logic [Y_W-1:0] y0_o,
  output logic [X_W-1:0] w_o,
  output logic [Y_W-1:0] h_o,
  output logic [T_W-1:0] b_o,
  output logic [T_W-1:0] i_o
);
  logic [X_W-1:0] x_al;

  generate
    if (X_ALIGN_LOG2 == 0) begin : g_no_align
      assign x_al = roi_x_i;
    end else begin : g_align
      assign x_al = {roi_x_i[X_W-1:X_ALIGN_LOG2], {X_ALIGN_LOG2{1'b0}}};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x0_o <= '0;
      y0_o <= '0;
      w_o  <= X_W'(1);
      h_o  <= Y_W'(1);
      b_o  <= T_W'(1);
      i_o  <= T_W'(1);
    end else if (load_i) begin
      x0_o <= x_al;
      y0_o <= roi_y_i;
      w_o  <= (width_i  == '0) ? X_W'(1) : width_i;
      h_o  <= (height_i == '0) ? Y_W'(1) : height_i;
      b_o  <= (blank_i  == '0) ? T_W'(1) : blank_i;
      i_o  <= (integ_i  == '0) ? T_W'(1) : integ_i;
    end
  end
endmodule

// File: rtl/readout_ctrl.sv
module readout_ctrl
  import readout_seq_pkg::*;
#(
  parameter int X_W = 11,
  parameter int Y_W = 10,
  parameter int T_W = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic           global_i,
  input  logic [X_W-1:0] w_i,
  input  logic [Y_W-1:0] h_i,
  input  logic [T_W-1:0] b_i,
  input  logic [T_W-1:0] i_i,
  output logic           accept_o,
  output seq_state_e     state_o,
  output logic [T_W-1:0] tcnt_o,
  output logic [X_W-1:0] px_o,
  output logic [Y_W-1:0] ln_o
);
  seq_state_e     st_q, st_d;
  logic [T_W-1:0] t_q, t_d;
  logic [X_W-1:0] px_q, px_d;
  logic [Y_W-1:0] ln_q, ln_d;

  always_comb begin
    st_d     = st_q;
    t_d      = t_q;
    px_d     = px_q;
    ln_d     = ln_q;
    accept_o = 1'b0;
    unique case (st_q)
      ST_IDLE, ST_DONE: begin
        if (start_i) begin
          accept_o = 1'b1;
          st_d     = global_i ? ST_EXPOSE : ST_FSTART;
          t_d      = '0;
        end else begin
          st_d = ST_IDLE;
        end
      end
      ST_EXPOSE: begin
        if (t_q == i_i) st_d = ST_FSTART;
        else            t_d  = t_q + T_W'(1);
      end
      ST_FSTART: begin
        st_d = ST_BLANK;
        t_d  = '0;
        ln_d = '0;
      end
      ST_BLANK: begin
        if (t_q == b_i - T_W'(1)) begin
          st_d = ST_PIXEL;
          px_d = '0;
        end else begin
          t_d = t_q + T_W'(1);
        end
      end
      ST_PIXEL: begin
        if (px_q == w_i - X_W'(1)) begin
          if (ln_q == h_i - Y_W'(1)) begin
            st_d = ST_DONE;
          end else begin
            st_d = ST_BLANK;
            t_d  = '0;
            ln_d = ln_q + Y_W'(1);
          end
        end else begin
          px_d = px_q + X_W'(1);
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE;
      t_q  <= '0;
      px_q <= '0;
      ln_q <= '0;
    end else begin
      st_q <= st_d;
      t_q  <= t_d;
      px_q <= px_d;
      ln_q <= ln_d;
    end
  end

  assign state_o = st_q;
  assign tcnt_o  = t_q;
  assign px_o    = px_q;
  assign ln_o    = ln_q;
endmodule

// File: rtl/readout_strobes.sv
module readout_strobes
  import readout_seq_pkg::*;
#(
  parameter int X_W = 11,
  parameter int Y_W = 10,
  parameter int T_W = 16
) (
  input  seq_state_e     state_i,
  input  logic [T_W-1:0] tcnt_i,
  input  logic [X_W-1:0] px_i,
  input  logic [Y_W-1:0] ln_i,
  input  logic [X_W-1:0] x0_i,
  input  logic [Y_W-1:0] y0_i,
  input  logic [T_W-1:0] b_i,
  input  logic [T_W-1:0] i_i,
  output logic           frame_start_o,
  output logic           row_adv_o,
  output logic           col_load_o,
  output logic           shut_open_o,
  output logic           shut_close_o,
  output logic           pix_valid_o,
  output logic [Y_W-1:0] line_o,
  output logic [X_W-1:0] pixel_o,
  output logic           frame_done_o
);
  logic in_exp, in_blank;

  assign in_exp        = (state_i == ST_EXPOSE);
  assign in_blank      = (state_i == ST_BLANK);
  assign frame_start_o = (state_i == ST_FSTART);
  assign shut_open_o   = in_exp && (tcnt_i == '0);
  assign shut_close_o  = in_exp && (tcnt_i == i_i);
  assign row_adv_o     = in_blank && (tcnt_i == '0);
  assign col_load_o    = in_blank && (tcnt_i == b_i - T_W'(1));
  assign pix_valid_o   = (state_i == ST_PIXEL);
  assign frame_done_o  = (state_i == ST_DONE);
  assign pixel_o       = x0_i + px_i;
  assign line_o        = y0_i + ln_i;
endmodule

// File: rtl/sensor_readout_seq.sv
module sensor_readout_seq
  import readout_seq_pkg::*;
#(
  parameter int X_W = 11,
  parameter int Y_W = 10,
  parameter int T_W = 16,
  parameter int X_ALIGN_LOG2 = 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic           global_mode_i,
  input  logic [X_W-1:0] roi_x_i,
  input  logic [Y_W-1:0] roi_y_i,
  input  logic [X_W-1:0] width_i,
  input  logic [Y_W-1:0] height_i,
  input  logic [T_W-1:0] blank_cyc_i,
  input  logic [T_W-1:0] integ_cyc_i,
  output logic           frame_start_o,
  output logic           row_adv_o,
  output logic           col_load_o,
  output logic           shut_open_o,
  output logic           shut_close_o,
  output logic           pix_valid_o,
  output logic [Y_W-1:0] line_o,
  output logic [X_W-1:0] pixel_o,
  output logic           frame_done_o
);
  logic           accept;
  seq_state_e     state;
  logic [T_W-1:0] tcnt, cfg_b, cfg_i;
  logic [X_W-1:0] px, cfg_x0, cfg_w;
  logic [Y_W-1:0] ln, cfg_y0, cfg_h;

  readout_cfg #(.X_W(X_W), .Y_W(Y_W), .T_W(T_W), .X_ALIGN_LOG2(X_ALIGN_LOG2)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (accept),
    .roi_x_i (roi_x_i),
    .roi_y_i (roi_y_i),
    .width_i (width_i),
    .height_i(height_i),
    .blank_i (blank_cyc_i),
    .integ_i (integ_cyc_i),
    .x0_o    (cfg_x0),
    .y0_o    (cfg_y0),
    .w_o     (cfg_w),
    .h_o     (cfg_h),
    .b_o     (cfg_b),
    .i_o     (cfg_i)
  );

  readout_ctrl #(.X_W(X_W), .Y_W(Y_W), .T_W(T_W)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .global_i(global_mode_i),
    .w_i     (cfg_w),
    .h_i     (cfg_h),
    .b_i     (cfg_b),
    .i_i     (cfg_i),
    .accept_o(accept),
    .state_o (state),
    .tcnt_o  (tcnt),
    .px_o    (px),
    .ln_o    (ln)
  );

  readout_strobes #(.X_W(X_W), .Y_W(Y_W), .T_W(T_W)) u_strb (
    .state_i      (state),
    .tcnt_i       (tcnt),
    .px_i         (px),
    .ln_i         (ln),
    .x0_i         (cfg_x0),
    .y0_i         (cfg_y0),
    .b_i          (cfg_b),
    .i_i          (cfg_i),
    .frame_start_o(frame_start_o),
    .row_adv_o    (row_adv_o),
    .col_load_o   (col_load_o),
    .shut_open_o  (shut_open_o),
    .shut_close_o (shut_close_o),
    .pix_valid_o  (pix_valid_o),
    .line_o       (line_o),
    .pixel_o      (pixel_o),
    .frame_done_o (frame_done_o)
  );
endmodule

// File: rtl/sensor_readout_seq_chk.sv
module sensor_readout_seq_chk #(
  parameter int X_W = 11
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           frame_start_o,
  input logic           row_adv_o,
  input logic           col_load_o,
  input logic           shut_open_o,
  input logic           shut_close_o,
  input logic           pix_valid_o,
  input logic [X_W-1:0] pixel_o,
  input logic           frame_done_o
);
  AST_PHASE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({frame_start_o, pix_valid_o, shut_open_o, shut_close_o, frame_done_o})); // R6

  AST_ROW_AFTER_FSTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |=> row_adv_o); // R3

  AST_LOAD_BEFORE_PIX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pix_valid_o) |-> $past(col_load_o)); // R4

  AST_LOAD_THEN_PIX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    col_load_o |=> pix_valid_o); // R4

  AST_EVEN_ORIGIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pix_valid_o) |-> (pixel_o[0] == 1'b0)); // R5

  AST_CLOSE_THEN_FSTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shut_close_o |=> frame_start_o); // R6

  AST_DONE_AFTER_PIX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |-> $past(pix_valid_o)); // R2
endmodule

bind sensor_readout_seq sensor_readout_seq_chk #(.X_W(X_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .frame_start_o(frame_start_o),
  .row_adv_o    (row_adv_o),
  .col_load_o   (col_load_o),
  .shut_open_o  (shut_open_o),
  .shut_close_o (shut_close_o),
  .pix_valid_o  (pix_valid_o),
  .pixel_o      (pixel_o),
  .frame_done_o (frame_done_o)
);

// File: tb/tb_sensor_readout_seq.sv
`timescale 1ns/1ps
module tb_sensor_readout_seq;
  localparam int X_W = 11;
  localparam int Y_W = 10;
  localparam int T_W = 16;

  typedef struct packed {
    logic           glb;
    logic [X_W-1:0] x;
    logic [Y_W-1:0] y;
    logic [X_W-1:0] w;
    logic [Y_W-1:0] h;
    logic [T_W-1:0] b;
    logic [T_W-1:0] i;
  } stim_t;

  // mode, x, y, w, h, blank, integ
  localparam stim_t VEC [6] = '{
    '{1'b0, 11'd4,  10'd10, 11'd5, 10'd3, 16'd3, 16'd0},
    '{1'b0, 11'd7,  10'd0,  11'd1, 10'd1, 16'd1, 16'd0},
    '{1'b1, 11'd2,  10'd5,  11'd4, 10'd2, 16'd2, 16'd5},
    '{1'b1, 11'd9,  10'd3,  11'd3, 10'd4, 16'd1, 16'd1},
    '{1'b0, 11'd0,  10'd0,  11'd0, 10'd0, 16'd0, 16'd0},
    '{1'b1, 11'd11, 10'd7,  11'd2, 10'd2, 16'd0, 16'd0}
  };

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic           glb = 1'b0;
  logic [X_W-1:0] roi_x = '0;
  logic [Y_W-1:0] roi_y = '0;
  logic [X_W-1:0] width = '0;
  logic [Y_W-1:0] height = '0;
  logic [T_W-1:0] blank = '0;
  logic [T_W-1:0] integ = '0;
  logic fs, ra, cl, so, sc, pv, fd;
  logic [Y_W-1:0] line;
  logic [X_W-1:0] pixel;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  sensor_readout_seq #(.X_W(X_W), .Y_W(Y_W), .T_W(T_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .global_mode_i(glb),
    .roi_x_i(roi_x), .roi_y_i(roi_y), .width_i(width), .height_i(height),
    .blank_cyc_i(blank), .integ_cyc_i(integ),
    .frame_start_o(fs), .row_adv_o(ra), .col_load_o(cl), .shut_open_o(so),
    .shut_close_o(sc), .pix_valid_o(pv), .line_o(line), .pixel_o(pixel),
    .frame_done_o(fd)
  );

  function automatic int nz(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic check_idle(input string req);
    n_chk++;
    if ({fs, ra, cl, so, sc, pv, fd} !== 7'b0) begin
      n_fail++;
      $display("FAIL %s strobes actual=%b expected=0000000", req, {fs, ra, cl, so, sc, pv, fd});
    end
  endtask

  // poke: request plus input changes mid-frame (R8); chain: request in done cycle (R9)
  task automatic run_frame(input stim_t s, input bit poke, input bit chain);
    int b, w, h, ig, ln_len, pre, done_k, last_k;
    b = nz(int'(s.b)); w = nz(int'(s.w)); h = nz(int'(s.h)); ig = nz(int'(s.i));
    ln_len = b + w;
    pre = s.glb ? ig + 1 : 0;
    done_k = pre + 2 + h * ln_len;
    last_k = chain ? done_k + 1 : done_k + 3;
    @(negedge clk);
    glb = s.glb; roi_x = s.x; roi_y = s.y; width = s.w; height = s.h;
    blank = s.b; integ = s.i; start = 1'b1;
    for (int k = 1; k <= last_k; k++) begin
      logic [6:0] ex;
      logic [X_W-1:0] ex_px;
      logic [Y_W-1:0] ex_ln;
      int o;
      @(negedge clk);
      start = (poke && k == 3) || (chain && k == done_k);
      if (poke && k == 3) begin
        glb = ~s.glb; roi_x = s.x + X_W'(6); width = s.w + X_W'(2); blank = s.b + T_W'(3);
      end
      o = k - pre;
      ex = '0; ex_px = '0; ex_ln = '0;
      if (s.glb && k == 1) ex[4] = 1'b1;            // R6 open
      if (s.glb && k == 1 + ig) ex[3] = 1'b1;       // R6 close
      if (o == 1) ex[6] = 1'b1;                     // R2 frame start
      if (o >= 2 && o < 2 + h * ln_len) begin
        int r, j, p;
        r = o - 2; j = r / ln_len; p = r % ln_len;
        if (p == 0) ex[5] = 1'b1;                   // R3 row advance
        if (p == b - 1) ex[2] = 1'b1;               // R4 column load
        if (p >= b) begin                           // R5 addresses
          ex[1] = 1'b1;
          ex_px = {s.x[X_W-1:1], 1'b0} + X_W'(p - b);
          ex_ln = s.y + Y_W'(j);
        end
      end
      if (o == 2 + h * ln_len) ex[0] = 1'b1;        // R2 done
      if (chain && k == done_k + 1) ex[6] = 1'b1;   // R9 back-to-back
      n_chk++;
      if ({fs, ra, so, sc, cl, pv, fd} !== {ex[6], ex[5], ex[4], ex[3], ex[2], ex[1], ex[0]} ||
          (ex[1] && (pixel !== ex_px || line !== ex_ln))) begin
        n_fail++;
        $display("FAIL %s k=%0d actual=%b px=%0d ln=%0d expected=%b px=%0d ln=%0d",
                 chain ? "R9" : (poke ? "R8" : (s.glb ? "R6" : "R2/R3/R4/R5/R7")), k,
                 {fs, ra, so, sc, cl, pv, fd}, pixel, line,
                 {ex[6], ex[5], ex[4], ex[3], ex[2], ex[1], ex[0]}, ex_px, ex_ln);
      end
    end
    start = 1'b0;
    if (chain) begin
      repeat (1 + h * ln_len) @(negedge clk);
      n_chk++;
      if (fd !== 1'b1) begin
        n_fail++;
        $display("FAIL R9 chained frame_done actual=%b expected=1", fd);
      end
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_idle("R1");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_idle("R1");

    foreach (VEC[v]) run_frame(VEC[v], 1'b0, 1'b0);

    // R7: zero settings behave as one (vectors 4 and 5 also cover it)
    run_frame('{1'b1, 11'd3, 10'd2, 11'd0, 10'd1, 16'd0, 16'd0}, 1'b0, 1'b0);
    // R8: mid-frame request and input changes ignored
    run_frame(VEC[0], 1'b1, 1'b0);
    run_frame(VEC[2], 1'b1, 1'b0);
    // R9: request in done cycle
    run_frame(VEC[1], 1'b0, 1'b1);
    run_frame(VEC[0], 1'b0, 1'b1);

    repeat (2) @(negedge clk);
    check_idle("R1");
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule